// File: doc/BRIEF.md
# Backlight PWM Generator

This block drives one pulse-width-modulated output for a display backlight. Software programs it through a small register space with plain read and write strobes. A prescaler sets how many input clocks make one PWM tick. A period count sets how many ticks make one PWM cycle. A high-width count sets how many ticks at the start of each cycle the output is high. The high-width field is one bit wider than the period field, so a full 100% duty can be reached.

By default the prescaler, period and high-width fields are shadow copies. They reach the counters only when software commits them. The commit is taken at the end of the PWM cycle in progress, so no cycle is ever cut short or stretched. When the output is disabled, the commit takes effect at once. A build-time parameter removes the shadow stage, and register writes then act immediately.

There is no streaming data path. All pins are plain control and status, and a read returns data in the same cycle as its strobe.

Top module: `bl_pwm`

## Requirements
- R1: After reset, `pwm_out` is low and every mapped register reads zero.
- R2: Register reads and writes:
  - The control register (0x10) and the period/width register (0x14) read back all 32 bits exactly as written.
  - The enable register (0x00) and the commit register (0x08) read back only bit 0; their other bits read zero.
  - Unmapped offsets read zero.
  - `rdata` is zero whenever `rd_en` is low.
- R3: Each PWM tick lasts (div+1) input clocks, where div is bits 25:16 of the control register.
- R4: Each PWM cycle lasts (per+1) ticks, where per is bits 11:0 of register 0x14. The output is high for the first hw ticks of every cycle, where hw is bits 28:16 of register 0x14.
- R5: When hw is greater than per, the output stays high for the whole cycle. When hw is zero, the output stays low.
- R6: Bit 0 of register 0x00 enables the output.
  - Clearing it drives `pwm_out` low in the clock after the write edge.
  - Clearing it also clears the tick and cycle counters, so setting it again starts a fresh cycle at tick 0.
- R7: With double buffering on, writes to the control and period/width registers do not change the output until a commit. A commit is a write of 1 and then a write of 0 to bit 0 of register 0x08; the write of 0 that clears the set bit is the commit event.
- R8: A commit made while the output runs takes effect at the end of the PWM cycle in progress, and that cycle finishes with the old values. If the commit event falls on the last clock of a cycle, the next cycle already uses the new values.
- R9: A commit made while the output is disabled loads the new values on the commit write edge.
- R10: With the parameter `DOUBLE_BUF` set to 0, writes to the control and period/width registers take effect at once, with no commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per clock |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low |
| pwm_out | output | 1 | PWM output |

## Verification
The commit event and the end of a PWM cycle can fall in the same clock, and the test provokes this directly. While one setting is running, the bench issues the commit write that clears the commit bit at three points: mid-cycle, exactly on the last clock of a cycle, and on the first clock of a new cycle. In each case the bench computes the boundary at which the switch must occur and checks every clock on both sides against the arithmetic waveform of the old and new settings. Disabling in mid-cycle, against an output that would otherwise be high, is judged the same way. A sweep over every small prescaler, period and width combination, run on both the buffered build and the unbuffered build, checks the basic waveform.

// File: rtl/bl_pwm_pkg.sv
`timescale 1ns/1ps
package bl_pwm_pkg;
  localparam int REG_W = 32;

  // register offsets
  localparam logic [7:0] OFF_ENA  = 8'h00;
  localparam logic [7:0] OFF_CMT  = 8'h08;
  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_PW   = 8'h14;

  // field positions
  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HW_LSB  = 16;
endpackage

// File: rtl/bl_regs.sv
`timescale 1ns/1ps
module bl_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HW_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              en,
  output logic              commit_evt,
  output logic [DIV_W-1:0]  sh_div,
  output logic [PER_W-1:0]  sh_per,
  output logic [HW_W-1:0]   sh_hw
);
  logic [REG_W-1:0] ctrl_q, pw_q;
  logic             en_q, cmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pw_q   <= '0;
      en_q   <= 1'b0;
      cmt_q  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(OFF_ENA):  en_q   <= wdata[0];
        ADDR_W'(OFF_CMT):  cmt_q  <= wdata[0];
        ADDR_W'(OFF_CTRL): ctrl_q <= wdata;
        ADDR_W'(OFF_PW):   pw_q   <= wdata;
        default: ;
      endcase
    end
  end

  // commit fires on the write that clears a set commit bit
  assign commit_evt = wr_en && (addr == ADDR_W'(OFF_CMT)) && !wdata[0] && cmt_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(OFF_ENA):  rdata = {{(REG_W-1){1'b0}}, en_q};
        ADDR_W'(OFF_CMT):  rdata = {{(REG_W-1){1'b0}}, cmt_q};
        ADDR_W'(OFF_CTRL): rdata = ctrl_q;
        ADDR_W'(OFF_PW):   rdata = pw_q;
        default:           rdata = '0;
      endcase
    end
  end

  assign en     = en_q;
  assign sh_div = ctrl_q[DIV_LSB +: DIV_W];
  assign sh_per = pw_q[PER_LSB +: PER_W];
  assign sh_hw  = pw_q[HW_LSB +: HW_W];
endmodule

// File: rtl/bl_stage.sv
`timescale 1ns/1ps
module bl_stage #(
  parameter int DIV_W      = 10,
  parameter int PER_W      = 12,
  parameter int HW_W       = 13,
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             boundary,
  input  logic             commit_evt,
  input  logic [DIV_W-1:0] sh_div,
  input  logic [PER_W-1:0] sh_per,
  input  logic [HW_W-1:0]  sh_hw,
  output logic [DIV_W-1:0] act_div,
  output logic [PER_W-1:0] act_per,
  output logic [HW_W-1:0]  act_hw
);
  generate
    if (DOUBLE_BUF) begin : g_buf
      logic pend_q, want, load_now;
      logic [DIV_W-1:0] div_q;
      logic [PER_W-1:0] per_q;
      logic [HW_W-1:0]  hw_q;

      assign want     = commit_evt || pend_q;
      assign load_now = want && (!en || boundary);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          div_q  <= '0;
          per_q  <= '0;
          hw_q   <= '0;
        end else begin
          pend_q <= want && !load_now;
          if (load_now) begin
            div_q <= sh_div;
            per_q <= sh_per;
            hw_q  <= sh_hw;
          end
        end
      end

      assign act_div = div_q;
      assign act_per = per_q;
      assign act_hw  = hw_q;
    end else begin : g_direct
      assign act_div = sh_div;
      assign act_per = sh_per;
      assign act_hw  = sh_hw;
    end
  endgenerate
endmodule

// File: rtl/bl_tick.sv
`timescale 1ns/1ps
module bl_tick #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [DIV_W-1:0] div_cnt
);
  assign tick = en && (div_cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_cnt <= '0;
    else if (!en || tick)  div_cnt <= '0;
    else                   div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/bl_wave.sv
`timescale 1ns/1ps
module bl_wave #(
  parameter int PER_W = 12,
  parameter int HW_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [PER_W-1:0] per,
  input  logic [HW_W-1:0]  hw,
  output logic             boundary,
  output logic [PER_W-1:0] cyc_cnt,
  output logic             wave
);
  logic last;

  assign last     = (cyc_cnt >= per);
  assign boundary = tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc_cnt <= '0;
    else if (!en)      cyc_cnt <= '0;
    else if (tick)     cyc_cnt <= last ? '0 : cyc_cnt + 1'b1;
  end

  assign wave = en && (HW_W'(cyc_cnt) < hw);
endmodule

// File: rtl/bl_pwm.sv
`timescale 1ns/1ps
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DIV_W      = 10,
  parameter int PER_W      = 12,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int HW_W      = PER_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              pwm_out
);
  logic             en, commit_evt, tick, boundary;
  logic [DIV_W-1:0] sh_div, act_div, div_cnt;
  logic [PER_W-1:0] sh_per, act_per, cyc_cnt;
  logic [HW_W-1:0]  sh_hw, act_hw;

  bl_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .PER_W(PER_W), .HW_W(HW_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .en(en), .commit_evt(commit_evt),
    .sh_div(sh_div), .sh_per(sh_per), .sh_hw(sh_hw)
  );

  bl_stage #(.DIV_W(DIV_W), .PER_W(PER_W), .HW_W(HW_W), .DOUBLE_BUF(DOUBLE_BUF)) u_stage (
    .clk(clk), .rst_n(rst_n), .en(en), .boundary(boundary),
    .commit_evt(commit_evt), .sh_div(sh_div), .sh_per(sh_per), .sh_hw(sh_hw),
    .act_div(act_div), .act_per(act_per), .act_hw(act_hw)
  );

  bl_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .div(act_div),
    .tick(tick), .div_cnt(div_cnt)
  );

  bl_wave #(.PER_W(PER_W), .HW_W(HW_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .per(act_per),
    .hw(act_hw), .boundary(boundary), .cyc_cnt(cyc_cnt), .wave(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
`timescale 1ns/1ps
module bl_pwm_chk #(
  parameter int DIV_W      = 10,
  parameter int PER_W      = 12,
  parameter int HW_W       = 13,
  parameter bit DOUBLE_BUF = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm_out,
  input logic             boundary,
  input logic [DIV_W-1:0] div_cnt,
  input logic [PER_W-1:0] cyc_cnt,
  input logic [DIV_W-1:0] act_div,
  input logic [PER_W-1:0] act_per,
  input logic [HW_W-1:0]  act_hw
);
  a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  a_r6_counters_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (div_cnt == '0 && cyc_cnt == '0));

  a_r5_zero_width_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hw == '0) |-> !pwm_out);

  a_r5_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_hw > HW_W'(act_per)) |-> pwm_out);

  a_r8_restart_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cyc_cnt == '0 && div_cnt == '0));

  a_r8_hold_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n || !DOUBLE_BUF)
    (en && !boundary) |=> ($stable(act_div) && $stable(act_per) && $stable(act_hw)));
endmodule

bind bl_pwm bl_pwm_chk #(
  .DIV_W(DIV_W), .PER_W(PER_W), .HW_W(HW_W), .DOUBLE_BUF(DOUBLE_BUF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_out(pwm_out), .boundary(boundary),
  .div_cnt(div_cnt), .cyc_cnt(cyc_cnt), .act_div(act_div),
  .act_per(act_per), .act_hw(act_hw)
);

// File: tb/bl_pwm_test.sv
`timescale 1ns/1ps
module bl_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nb;
  logic        pwm_out, pwm_nb;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bl_pwm uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  bl_pwm #(.DOUBLE_BUF(1'b0)) uut_nb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_nb), .pwm_out(pwm_nb)
  );

  localparam logic [7:0] A_ENA = 8'h00, A_CMT = 8'h08, A_CTRL = 8'h10, A_PW = 8'h14;

  function automatic bit expect_out(int k, int d, int p, int h);
    int t;
    t = k / (d + 1);
    return (t % (p + 1)) < h;
  endfunction

  function automatic logic [31:0] pw_word(int p, int h);
    return (32'(h) << 16) | 32'(p);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one register write; returns at the negedge after its edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic program_idle(int d, int p, int h);
    wr(A_ENA, 32'd0);
    wr(A_CTRL, 32'(d) << 16);
    wr(A_PW, pw_word(p, h));
    wr(A_CMT, 32'd1);
    wr(A_CMT, 32'd0);   // R9: loads while disabled
  endtask

  // commit while running; cc is the sample index of the commit-clearing write
  task automatic run_commit(int cc);
    int ln, mm, dA, pA, hA, dB, pB, hB;
    dA = 1; pA = 3; hA = 2; dB = 0; pB = 1; hB = 1;
    ln = (dA + 1) * (pA + 1);
    mm = cc;
    while (((mm + 1) % ln) != 0) mm++;
    program_idle(dA, pA, hA);
    wr(A_ENA, 32'd1);
    for (int k = 0; k < mm + 12; k++) begin
      bit e;
      if (k <= mm) e = expect_out(k, dA, pA, hA);
      else         e = expect_out(k - mm - 1, dB, pB, hB);
      check(k <= mm ? "R8 old values until boundary" : "R8 new values after boundary",
            {31'd0, pwm_out}, {31'd0, e});
      wr_en = 1'b0;
      if (k == cc - 3) begin wr_en = 1'b1; addr = A_PW;   wdata = pw_word(pB, hB); end
      if (k == cc - 2) begin wr_en = 1'b1; addr = A_CTRL; wdata = 32'(dB) << 16;   end
      if (k == cc - 1) begin wr_en = 1'b1; addr = A_CMT;  wdata = 32'd1;           end
      if (k == cc)     begin wr_en = 1'b1; addr = A_CMT;  wdata = 32'd0;           end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 output low", {31'd0, pwm_out}, 32'd0);
    rd(A_ENA, v);  check("R1 enable reads 0", v, 32'd0);
    rd(A_CMT, v);  check("R1 commit reads 0", v, 32'd0);
    rd(A_CTRL, v); check("R1 control reads 0", v, 32'd0);
    rd(A_PW, v);   check("R1 period/width reads 0", v, 32'd0);

    // R2 read back
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R2 control all bits", v, 32'hFFFF_FFFF);
    wr(A_PW, 32'hDEAD_BEEF);   rd(A_PW, v);   check("R2 period/width all bits", v, 32'hDEAD_BEEF);
    wr(A_ENA, 32'hFFFF_FFFE);  rd(A_ENA, v);  check("R2 enable bit0 only", v, 32'd0);
    wr(A_CMT, 32'hFFFF_FFFF);  rd(A_CMT, v);  check("R2 commit bit0 only", v, 32'd1);
    wr(A_CMT, 32'd0);
    rd(8'h04, v); check("R2 unmapped 0x04", v, 32'd0);
    rd(8'h0C, v); check("R2 unmapped 0x0C", v, 32'd0);
    rd(8'h18, v); check("R2 unmapped 0x18", v, 32'd0);
    @(negedge clk); addr = A_CTRL; #1 check("R2 rdata zero without rd_en", rdata, 32'd0);

    // R3 R4 R5 R9 R10 sweep on both builds
    for (int d = 0; d < 3; d++)
      for (int p = 0; p < 4; p++)
        for (int h = 0; h < 6; h++) begin
          int ln;
          ln = (d + 1) * (p + 1);
          program_idle(d, p, h);
          wr(A_ENA, 32'd1);
          for (int k = 0; k < 2 * ln + 2; k++) begin
            bit e;
            e = expect_out(k, d, p, h);
            check(h > p ? "R5 full duty" : (h == 0 ? "R5 zero width" : "R3 R4 waveform"),
                  {31'd0, pwm_out}, {31'd0, e});
            check("R10 unbuffered waveform", {31'd0, pwm_nb}, {31'd0, e});
            @(negedge clk);
          end
        end

    // R7 R10: shadow write without commit (last config d=2 p=3 h=5)
    wr(A_ENA, 32'd0);
    wr(A_PW, pw_word(3, 1));
    wr(A_ENA, 32'd1);
    for (int k = 0; k < 14; k++) begin
      check("R7 uncommitted write ignored", {31'd0, pwm_out}, {31'd0, expect_out(k, 2, 3, 5)});
      check("R10 write acts at once", {31'd0, pwm_nb}, {31'd0, expect_out(k, 2, 3, 1)});
      @(negedge clk);
    end

    // R8 commit mid-cycle, on the last clock, on the first clock of a cycle
    run_commit(5);
    run_commit(7);
    run_commit(8);

    // R6 disable mid-cycle and restart
    program_idle(1, 3, 3);
    wr(A_ENA, 32'd1);
    for (int k = 0; k < 20; k++) begin
      bit e;
      if (k < 4)       e = expect_out(k, 1, 3, 3);
      else if (k < 6)  e = 1'b0;
      else             e = expect_out(k - 6, 1, 3, 3);
      check(k < 6 ? "R6 low when disabled" : "R6 fresh cycle on re-enable",
            {31'd0, pwm_out}, {31'd0, e});
      wr_en = 1'b0;
      if (k == 3) begin wr_en = 1'b1; addr = A_ENA; wdata = 32'd0; end
      if (k == 5) begin wr_en = 1'b1; addr = A_ENA; wdata = 32'd1; end
      @(negedge clk);
    end
    wr_en = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule